// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the lowest layer of an I2C master. It turns single commands from a controller into waveforms on open-drain SCL and SDA lines. The commands are start, stop, byte write with acknowledge sampling, byte read with a chosen acknowledge reply, and a bus-recovery sweep. Each command is a fixed list of steps. Every step sets the two line levels and then holds them for one quarter of the I2C bit period. A run-time count of system clocks sets the length of that quarter.

The controller offers a command with a valid/ready handshake. It then waits for a one-cycle done pulse, and ready returns in that same cycle. At done, a read command leaves its byte on `rd_byte`, and a write command leaves the SDA level seen on the ninth clock on `ack_seen`. The pads are modelled as output enables: an enable of 1 pulls the line low, and an enable of 0 releases it to the pull-up. SDA is read back through `sda_in`.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, both output enables are 0 (lines released), `cmd_ready` is 1 and `done` is 0.
- R2: A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high and a defined op code (1 start, 2 stop, 3 write, 4 read, 5 recovery). From the next cycle `cmd_ready` is 0. It returns to 1 in the cycle where `done` is high, and `done` stays high for exactly one cycle.
- R3: Each step lasts Q system clocks, where Q = `qdiv`. A `qdiv` of 0 gives Q = 1. The first step's levels appear in the cycle after acceptance, and `done` rises in the cycle after the last step ends.
- R4: Start is 3 steps. Step 1 releases SDA and leaves SCL as it was. Step 2 releases SCL. Step 3 pulls SDA low while SCL stays high.
- R5: Stop is 4 steps. Step 1 pulls SCL low and leaves SDA as it was. Step 2 pulls SDA low. Step 3 releases SCL. Step 4 releases SDA.
- R6: Write sends `cmd_wbyte` MSB first. Each bit takes 4 steps: SCL low with SDA unchanged, SCL low with SDA set to the bit, then SCL high for two steps. During write, read and the recovery sweep, SDA never changes while SCL stays high.
- R7: After the 8 data bits, write gives a ninth bit slot of the same shape with SDA released. It samples `sda_in` on the last clock of that slot's second high step and places it on `ack_seen` (0 means the slave acknowledged). A final step then holds SCL low. A write is 37 steps in total.
- R8: Read keeps SDA released for 8 bit slots. Each slot is SCL low for one step, then SCL high for two steps. `sda_in` is sampled on the last clock of the first high step, and the bits are assembled MSB first into `rd_byte`.
- R9: After the 8 read bits there are 5 more steps: SCL low with SDA unchanged, SCL low with SDA set to `cmd_rack`, SCL high for two steps, then SCL low. `cmd_rack` = 0 drives an acknowledge and `cmd_rack` = 1 releases SDA as a no-acknowledge. A read is 29 steps.
- R10: Recovery holds SDA released for nine SCL pulses of two low steps and two high steps each. It then performs the stop of R5, for 40 steps in all.
- R11: A line is driven only to produce a low level. A high level is always produced by releasing the line, with its enable at 0.
- R12: A valid offer with an undefined op code (0, 6 or 7) is dropped. `cmd_ready` stays 1, no `done` follows, and both line enables keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| qdiv | input | DIV_W | System clocks per quarter-bit step (0 acts as 1) |
| cmd_valid | input | 1 | Command offer |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 3 | Op code: 1 start, 2 stop, 3 write, 4 read, 5 recovery |
| cmd_wbyte | input | 8 | Byte sent by a write command |
| cmd_rack | input | 1 | Acknowledge level returned after a read byte (0 acknowledge) |
| done | output | 1 | One-cycle pulse when a command finishes |
| rd_byte | output | 8 | Byte assembled by the last read |
| ack_seen | output | 1 | SDA level sampled on the ninth clock of the last write |
| scl_oe | output | 1 | SCL pull-low enable |
| sda_oe | output | 1 | SDA pull-low enable |
| sda_in | input | 1 | SDA line level as seen at the pad |

## Verification
The bench builds the engine with a 6-bit step counter. Between commands it changes `qdiv` to 3, 0, 1, 2 and 5. A `qdiv` of 0 or 1 gives single-clock steps, which checks that the first step and the step advance land on the right clocks when no idle counting hides an off-by-one. The larger values check that every level is held for the whole step. The slave model acknowledges one write and refuses another, and it presents read bytes with mixed bit patterns. This places the sampling clocks on both line levels and shows whether a sample is taken a step early or late.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 3;
    localparam int STEP_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4,
        OP_RECOVER = 3'd5
    } op_e;

    // Line levels for one step; a "hold" flag keeps the present level.
    typedef struct packed {
        logic scl_hold;
        logic scl;
        logic sda_hold;
        logic sda;
    } lvl_t;

    typedef struct packed {
        logic sample;
        logic last;
    } flg_t;

    typedef struct packed {
        lvl_t lv;
        flg_t fl;
    } step_t;

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        return (op >= OP_START) && (op <= OP_RECOVER);
    endfunction

    function automatic step_t stop_step(input int k);
        step_t s;
        s          = '0;
        s.lv.scl   = (k >= 2);
        s.lv.sda_hold = (k == 0);
        s.lv.sda   = (k == 3);
        s.fl.last  = (k == 3);
        return s;
    endfunction

    function automatic step_t step_of(input logic [OP_W-1:0] op,
                                      input logic [STEP_W-1:0] n,
                                      input logic [BYTE_W-1:0] wb,
                                      input logic rack);
        step_t s;
        int idx, b, q;
        s   = '0;
        idx = int'(n);
        case (op)
            OP_START: begin
                s.lv.scl_hold = (idx == 0);
                s.lv.scl      = 1'b1;
                s.lv.sda      = (idx != 2);
                s.fl.last     = (idx == 2);
            end
            OP_STOP: s = stop_step(idx);
            OP_WRITE: begin
                b = idx / 4;
                q = idx % 4;
                if (idx >= 36) begin
                    s.lv.sda  = 1'b1;
                    s.fl.last = 1'b1;
                end else begin
                    s.lv.scl      = (q >= 2);
                    s.lv.sda_hold = (q == 0);
                    s.lv.sda      = (b < 8) ? wb[3'(7 - b)] : 1'b1;
                    s.fl.sample   = (b == 8) && (q == 3);
                end
            end
            OP_READ: begin
                if (idx < 24) begin
                    q           = idx % 3;
                    s.lv.scl    = (q != 0);
                    s.lv.sda    = 1'b1;
                    s.fl.sample = (q == 1);
                end else begin
                    b             = idx - 24;
                    s.lv.scl      = (b == 2) || (b == 3);
                    s.lv.sda_hold = (b == 0);
                    s.lv.sda      = (b == 0) ? 1'b1 : rack;
                    s.fl.last     = (b >= 4);
                end
            end
            OP_RECOVER: begin
                if (idx < 36) begin
                    s.lv.scl = ((idx % 4) >= 2);
                    s.lv.sda = 1'b1;
                end else begin
                    s = stop_step(idx - 36);
                end
            end
            default: s.fl.last = 1'b1;
        endcase
        return s;
    endfunction

    function automatic lvl_t step_levels(input logic [OP_W-1:0] op,
                                         input logic [STEP_W-1:0] n,
                                         input logic [BYTE_W-1:0] wb,
                                         input logic rack);
        step_t s;
        s = step_of(op, n, wb, rack);
        return s.lv;
    endfunction

    function automatic flg_t step_flags(input logic [OP_W-1:0] op,
                                        input logic [STEP_W-1:0] n,
                                        input logic [BYTE_W-1:0] wb,
                                        input logic rack);
        step_t s;
        s = step_of(op, n, wb, rack);
        return s.fl;
    endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? DIV_W'(1) : div;
    assign tick = run && (cnt == lim - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/i2c_step_seq.sv
module i2c_step_seq
    import i2c_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic [BYTE_W-1:0] req_wb,
    input  logic              req_rack,
    input  logic              sda_in,
    output logic              busy,
    output logic              done,
    output logic              scl_lvl,
    output logic              sda_lvl,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_lvl
);
    logic [OP_W-1:0]   op_r;
    logic [STEP_W-1:0] n_r;
    logic [BYTE_W-1:0] wb_r;
    logic              rack_r;
    flg_t              cur_fl;
    lvl_t              nxt_lv, first_lv;
    logic              accept;

    assign accept   = req_valid && !busy && op_legal(req_op);
    assign cur_fl   = step_flags(op_r, n_r, wb_r, rack_r);
    assign nxt_lv   = step_levels(op_r, n_r + STEP_W'(1), wb_r, rack_r);
    assign first_lv = step_levels(req_op, '0, req_wb, req_rack);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            op_r    <= OP_NONE;
            n_r     <= '0;
            wb_r    <= '0;
            rack_r  <= 1'b1;
            scl_lvl <= 1'b1;
            sda_lvl <= 1'b1;
            rx_byte <= '0;
            ack_lvl <= 1'b1;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                op_r    <= req_op;
                n_r     <= '0;
                wb_r    <= req_wb;
                rack_r  <= req_rack;
                scl_lvl <= first_lv.scl_hold ? scl_lvl : first_lv.scl;
                sda_lvl <= first_lv.sda_hold ? sda_lvl : first_lv.sda;
            end else if (busy && tick) begin
                if (cur_fl.sample) begin
                    if (op_r == OP_WRITE) ack_lvl <= sda_in;
                    else                  rx_byte <= {rx_byte[BYTE_W-2:0], sda_in};
                end
                if (cur_fl.last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    n_r     <= n_r + STEP_W'(1);
                    scl_lvl <= nxt_lv.scl_hold ? scl_lvl : nxt_lv.scl;
                    sda_lvl <= nxt_lv.sda_hold ? sda_lvl : nxt_lv.sda;
                end
            end
        end
    end

    // R6: SDA moves under a high SCL only for start/stop conditions
    a_r6_sda_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(scl_lvl) && scl_lvl && !$stable(sda_lvl))
        |-> (op_r == OP_START || op_r == OP_STOP || op_r == OP_RECOVER))
        else $error("R6 SDA moved while SCL high");

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("R2 done longer than one cycle");

    a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("R2 done while busy");

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(scl_lvl) && $stable(sda_lvl)))
        else $error("R12 lines moved while idle");
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_eng_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  qdiv,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [BYTE_W-1:0] cmd_wbyte,
    input  logic              cmd_rack,
    output logic              done,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              ack_seen,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    logic busy, tick, scl_lvl, sda_lvl;

    i2c_qtick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (qdiv),
        .tick (tick)
    );

    i2c_step_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .req_valid (cmd_valid),
        .req_op    (cmd_op),
        .req_wb    (cmd_wbyte),
        .req_rack  (cmd_rack),
        .sda_in    (sda_in),
        .busy      (busy),
        .done      (done),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .rx_byte   (rd_byte),
        .ack_lvl   (ack_seen)
    );

    assign cmd_ready = !busy;
    // R11: open drain, enable only to pull low
    assign scl_oe = !scl_lvl;
    assign sda_oe = !sda_lvl;

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && op_legal(cmd_op)) |=> !cmd_ready)
        else $error("R2 ready stayed high after accept");
endmodule

// File: tb/i2c_bit_engine_test.sv
`timescale 1ns/1ps
module i2c_bit_engine_test;
    localparam int DIV_W = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst;
    logic [DIV_W-1:0] qdiv;
    logic             cmd_valid, cmd_ready, cmd_rack, done, ack_seen;
    logic [2:0]       cmd_op;
    logic [7:0]       cmd_wbyte, rd_byte;
    logic             scl_oe, sda_oe, sda_in, slv_low;

    assign sda_in = !(sda_oe || slv_low);

    i2c_bit_engine #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst(rst), .qdiv(qdiv), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wbyte(cmd_wbyte),
        .cmd_rack(cmd_rack), .done(done), .rd_byte(rd_byte),
        .ack_seen(ack_seen), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    int compared = 0, mismatched = 0;
    logic [2:0] expq[$];
    logic cur_scl, cur_sda;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    function automatic int qlen();
        return (qdiv == 0) ? 1 : int'(qdiv);
    endfunction

    task automatic step(input logic s, input logic d, input logic v);
        for (int i = 0; i < qlen(); i++) expq.push_back({s, d, v});
        cur_scl = s;
        cur_sda = d;
    endtask

    task automatic model_stop();
        step(0, cur_sda, 0); step(0, 0, 0); step(1, 0, 0); step(1, 1, 0);
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] wb, input logic rack,
                           input logic sack, input logic [7:0] sbyte, input string req);
        logic [2:0] e;
        logic bitv, v;
        case (op)
            3'd1: begin step(cur_scl, 1, 0); step(1, 1, 0); step(1, 0, 0); end
            3'd2: model_stop();
            3'd3: begin
                for (int b = 0; b < 9; b++) begin
                    bitv = (b < 8) ? wb[7-b] : 1'b1;
                    v = (b == 8) && sack;
                    step(0, cur_sda, v); step(0, bitv, v); step(1, bitv, v); step(1, bitv, v);
                end
                step(0, 1, 0);
            end
            3'd4: begin
                for (int b = 0; b < 8; b++) begin
                    v = !sbyte[7-b];
                    step(0, 1, v); step(1, 1, v); step(1, 1, v);
                end
                step(0, cur_sda, 0); step(0, rack, 0); step(1, rack, 0);
                step(1, rack, 0); step(0, rack, 0);
            end
            default: begin
                for (int k = 0; k < 36; k++) step((k % 4) >= 2, 1, 0);
                model_stop();
            end
        endcase
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_wbyte = wb; cmd_rack = rack;
        chk(cmd_ready == 1, "R2 ready before offer", int'(cmd_ready), 1);
        @(negedge clk);
        cmd_valid = 0;
        while (expq.size() > 0) begin
            e = expq.pop_front();
            slv_low = e[0];
            chk(scl_oe == !e[2] && sda_oe == !e[1] && !cmd_ready && !done, req,
                int'({scl_oe, sda_oe, cmd_ready, done}), int'({!e[2], !e[1], 2'b00}));
            @(negedge clk);
        end
        slv_low = 0;
        chk(done && cmd_ready, "R2 done with ready", int'({done, cmd_ready}), 3);
        chk(scl_oe == !cur_scl && sda_oe == !cur_sda, "R3 levels at done",
            int'({scl_oe, sda_oe}), int'({!cur_scl, !cur_sda}));
        if (op == 3'd3) chk(ack_seen == !sack, "R7 ack sample", int'(ack_seen), int'(!sack));
        if (op == 3'd4) chk(rd_byte == sbyte, "R8 read byte", int'(rd_byte), int'(sbyte));
        @(negedge clk);
        chk(!done, "R2 done one cycle", int'(done), 0);
    endtask

    task automatic bad_op(input logic [2:0] op);
        logic so, do_;
        @(negedge clk);
        so = scl_oe; do_ = sda_oe;
        cmd_valid = 1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 0;
        for (int i = 0; i < 6; i++) begin
            chk(cmd_ready && !done && scl_oe == so && sda_oe == do_, "R12 undefined op dropped",
                int'({cmd_ready, done, scl_oe, sda_oe}), int'({2'b10, so, do_}));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst = 1; qdiv = 3; cmd_valid = 0; cmd_op = 0; cmd_wbyte = 0; cmd_rack = 1; slv_low = 0;
        cur_scl = 1; cur_sda = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!scl_oe && !sda_oe && cmd_ready && !done, "R1 reset state",
            int'({scl_oe, sda_oe, cmd_ready, done}), 2);
        run_cmd(3'd5, 8'h00, 1, 0, 8'h00, "R10 recovery");
        run_cmd(3'd1, 8'h00, 1, 0, 8'h00, "R4 start");
        run_cmd(3'd3, 8'hA5, 1, 1, 8'h00, "R6 R7 write acked");
        run_cmd(3'd3, 8'h3C, 1, 0, 8'h00, "R7 write refused");
        bad_op(3'd0);
        run_cmd(3'd4, 8'h00, 0, 0, 8'h96, "R8 R9 read ack");
        run_cmd(3'd1, 8'h00, 1, 0, 8'h00, "R4 repeated start");
        qdiv = 0;
        run_cmd(3'd3, 8'h81, 1, 1, 8'h00, "R3 write qdiv0");
        run_cmd(3'd4, 8'h00, 1, 0, 8'h5B, "R3 R9 read nack qdiv0");
        bad_op(3'd6);
        qdiv = 1;
        run_cmd(3'd2, 8'h00, 1, 0, 8'h00, "R5 stop");
        qdiv = 2;
        run_cmd(3'd1, 8'h00, 1, 0, 8'h00, "R4 start q2");
        run_cmd(3'd4, 8'h00, 0, 0, 8'h01, "R8 read q2");
        bad_op(3'd7);
        qdiv = 5;
        run_cmd(3'd3, 8'h7E, 1, 1, 8'h00, "R6 R11 write q5");
        run_cmd(3'd2, 8'h00, 1, 0, 8'h00, "R5 R11 stop q5");
        summary();
        $finish;
    end
endmodule